// File: doc/BRIEF.md
# Glitchless Redundant Clock Switchover

This block selects one of two reference clocks, a primary and a secondary, and passes it to a single clock output. When the selection input changes, the output does not jump straight across. First the outgoing clock is gated off on one of its own falling edges, and the output then rests low. The closed state of that gate is carried into the incoming clock's domain, and only after it has passed through a chain of falling-edge flops there does the incoming clock's gate open. No shortened high or low pulse reaches the output.

A force input lets the change complete when the outgoing clock has died or is stuck at a DC level. The deselected gate is then cleared asynchronously, so none of its edges are needed. An asynchronous output enable sits after the clock multiplexer. While the enable is low, the output holds a static level taken from a separate input. A two-bit status output shows which gate is open. The synchroniser depth is a parameter, with a default of three falling edges per domain.

Top module: `ckswt_redundant_mux`

## Requirements
- R1: After `rst_n` rises, the gate of the selected source opens on the STAGES-th (default 3rd) falling edge of that source's clock, and not before.
- R2: `sel_sec` = 0 selects the primary clock and `sel_sec` = 1 selects the secondary clock. While a gate is open, `clk_out` follows that clock in phase.
- R3: After `sel_sec` changes, the outgoing gate closes on the 3rd falling edge of the outgoing clock, and `clk_out` stays low from then on.
- R4: The incoming gate opens on the 3rd falling edge of the incoming clock that follows the closing of the outgoing gate, and never while the outgoing chain still holds an open request.
- R5: `src_on` never equals 2'b11.
- R6: While `out_en` is steady high, `clk_out` shows no high or low pulse shorter than half a period of the faster source.
- R7: With `force_sw` high, the deselected gate is cleared at once without any edge of its own clock, and the selected gate opens on the 3rd falling edge of its clock.
- R8: While `out_en` is low, `clk_out` equals `park_lvl` at once. The gate state shown on `src_on` is not disturbed.
- R9: If `sel_sec` returns to its old value while the outgoing gate is still open, the original source ends up driving again and the other gate never opens.
- R10: `src_on` bit 0 is 1 while the primary gate is open, and bit 1 is 1 while the secondary gate is open.
- R11: `rst_n` low clears both gates asynchronously. With `out_en` high, `clk_out` is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous reset of both gate chains |
| clk_pri | input | 1 | Primary reference clock |
| clk_sec | input | 1 | Secondary reference clock |
| sel_sec | input | 1 | Source select: 0 primary, 1 secondary |
| force_sw | input | 1 | Forces the switch to complete without edges from the deselected clock; low at power-up |
| out_en | input | 1 | Asynchronous output enable, active high |
| park_lvl | input | 1 | Static output level while `out_en` is low |
| clk_out | output | 1 | Switched clock output |
| src_on | output | 2 | Open gates: bit 0 primary, bit 1 secondary |

## Verification
The assertions assume that `sel_sec` is asynchronous but well behaved. Once the outgoing gate has closed, `sel_sec` holds until the incoming gate has opened, so that the two synchronisers never see different selections at the same time. They also assume that `force_sw` is raised only together with a selection that points away from the dead clock. The stimulus reverts `sel_sec` only while the outgoing gate is still open. It stops the primary clock only while that clock is low, before raising force. The two clocks are offset by half a nanosecond, so their falling edges never coincide with each other or with the sampling points.

// File: rtl/ckswt_pkg.sv
`timescale 1ns/100ps
package ckswt_pkg;
   localparam int unsigned NSRC = 2;
   typedef enum logic {SRC_PRI = 1'b0, SRC_SEC = 1'b1} src_e;
endpackage

// File: rtl/ckswt_gate_chain.sv
`timescale 1ns/100ps
// Falling-edge gating chain for one source clock: the request is the
// selection qualified by the other chain being idle; it crosses into this
// domain through the chain itself.
module ckswt_gate_chain #(
   parameter int unsigned STAGES = 3
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic clr,
   input  logic want,
   input  logic other_busy,
   output logic gate,
   output logic busy
);
   localparam int unsigned CW = $clog2(STAGES + 1);
   localparam logic [CW-1:0] FULL = CW'(STAGES);

   if (STAGES < 2) begin : g_bad_depth
      $error("ckswt_gate_chain: STAGES must be at least 2");
   end

   logic              arst_n;
   logic              req;
   logic [STAGES-1:0] pipe;

   assign arst_n = rst_n & ~clr;
   assign req    = want & ~other_busy;

   always_ff @(negedge src_clk or negedge arst_n) begin
      if (!arst_n) begin
         pipe <= '0;
         busy <= 1'b0;
      end else begin
         pipe <= {pipe[STAGES-2:0], req};
         busy <= req | (|pipe[STAGES-2:0]);
      end
   end

   assign gate = pipe[STAGES-1];

   // checker state: run of idle requests and edges since release
   logic [CW-1:0] idle_run;
   logic [CW-1:0] age;

   always_ff @(negedge src_clk or negedge arst_n) begin
      if (!arst_n) begin
         idle_run <= '0;
         age      <= '0;
      end else begin
         if (req)                idle_run <= '0;
         else if (idle_run != FULL) idle_run <= idle_run + 1'b1;
         if (age != FULL)        age <= age + 1'b1;
      end
   end

   assert_min_latency_R1: assert property (@(negedge src_clk) disable iff (!rst_n)
      gate |-> (age >= FULL));

   assert_drop_in_time_R3: assert property (@(negedge src_clk) disable iff (!rst_n)
      (idle_run == FULL) |-> !gate);

   assert_wait_other_R4: assert property (@(negedge src_clk) disable iff (!rst_n)
      $rose(gate) |-> !other_busy);
endmodule

// File: rtl/ckswt_out_stage.sv
`timescale 1ns/100ps
// OR of the gated clocks followed by the asynchronous enable / park mux.
module ckswt_out_stage #(
   parameter int unsigned N = 2
) (
   input  logic [N-1:0] clk_v,
   input  logic [N-1:0] gate_v,
   input  logic         out_en,
   input  logic         park_lvl,
   output logic         clk_out
);
   logic [N-1:0] gated;

   for (genvar g = 0; g < N; g++) begin : g_gate
      assign gated[g] = clk_v[g] & gate_v[g];
   end

   assign clk_out = out_en ? (|gated) : park_lvl;
endmodule

// File: rtl/ckswt_redundant_mux.sv
`timescale 1ns/100ps
module ckswt_redundant_mux
   import ckswt_pkg::*;
#(
   parameter int unsigned STAGES = 3
) (
   input  logic       rst_n,
   input  logic       clk_pri,
   input  logic       clk_sec,
   input  logic       sel_sec,
   input  logic       force_sw,
   input  logic       out_en,
   input  logic       park_lvl,
   output logic       clk_out,
   output logic [1:0] src_on
);
   if (NSRC != 2) begin : g_bad_nsrc
      $error("ckswt_redundant_mux: exactly two sources supported");
   end

   logic [NSRC-1:0] clk_v;
   logic [NSRC-1:0] gate_v;
   logic [NSRC-1:0] busy_v;
   logic [NSRC-1:0] want_v;
   logic [NSRC-1:0] clr_v;

   assign clk_v = {clk_sec, clk_pri};

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      assign want_v[g] = (src_e'(sel_sec) == src_e'(g));
      assign clr_v[g]  = force_sw & ~want_v[g];

      ckswt_gate_chain #(.STAGES(STAGES)) i_chain (
         .src_clk    (clk_v[g]),
         .rst_n      (rst_n),
         .clr        (clr_v[g]),
         .want       (want_v[g]),
         .other_busy (busy_v[NSRC-1-g]),
         .gate       (gate_v[g]),
         .busy       (busy_v[g])
      );

      assert_no_overlap_R5: assert property (@(negedge clk_v[g]) disable iff (!rst_n)
         $countones(gate_v) <= 1);
   end

   ckswt_out_stage #(.N(NSRC)) i_out (
      .clk_v    (clk_v),
      .gate_v   (gate_v),
      .out_en   (out_en),
      .park_lvl (park_lvl),
      .clk_out  (clk_out)
   );

   assign src_on = gate_v;
endmodule

// File: tb/test_ckswt_redundant_mux.sv
`timescale 1ns/100ps
module test_ckswt_redundant_mux;
   logic       rst_n    = 1'b1;
   logic       clk_pri  = 1'b0;
   logic       clk_sec  = 1'b0;
   logic       sel_sec  = 1'b0;
   logic       force_sw = 1'b0;
   logic       out_en   = 1'b1;
   logic       park_lvl = 1'b0;
   logic       clk_out;
   logic [1:0] src_on;

   bit pri_run = 1'b1;
   bit sec_run = 1'b1;
   bit mon_en  = 1'b0;
   bit done    = 1'b0;
   int checks  = 0;
   int errors  = 0;
   int pri_negs = 0;
   int sec_negs = 0;
   int overlap_seen = 0;
   int runt_seen = 0;
   realtime last_edge = 0.0;
   bit last_valid = 1'b0;

   ckswt_redundant_mux #(.STAGES(3)) i_ckswt_redundant_mux (
      .rst_n(rst_n), .clk_pri(clk_pri), .clk_sec(clk_sec), .sel_sec(sel_sec),
      .force_sw(force_sw), .out_en(out_en), .park_lvl(park_lvl),
      .clk_out(clk_out), .src_on(src_on)
   );

   // 100 MHz primary; secondary 14 ns period, falling edges at x.5 ns
   always #5 if (pri_run || clk_pri) clk_pri = ~clk_pri;
   initial begin
      #0.5;
      forever #7 if (sec_run || clk_sec) clk_sec = ~clk_sec;
   end

   always @(negedge clk_pri) pri_negs++;
   always @(negedge clk_sec) sec_negs++;

   always @(src_on) if (src_on == 2'b11) overlap_seen++;

   always @(clk_out) begin
      if (mon_en && last_valid && ($realtime - last_edge) < 4.9) runt_seen++;
      last_edge  = $realtime;
      last_valid = mon_en;
   end

   task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wait_pri(input int base, input int n);
      wait (pri_negs == base + n);
      #1;
   endtask

   task automatic wait_sec(input int base, input int n);
      wait (sec_negs == base + n);
      #1;
   endtask

   // clk_out must track the given clock
   task automatic t_follow(input bit sec, input string tag);
      for (int k = 0; k < 3; k++) begin
         if (sec) @(posedge clk_sec); else @(posedge clk_pri);
         #2 check(tag, {1'b0, clk_out}, 2'b01);
         if (sec) @(negedge clk_sec); else @(negedge clk_pri);
         #2 check(tag, {1'b0, clk_out}, 2'b00);
      end
      check({tag, " status R10"}, src_on, sec ? 2'b10 : 2'b01);
   endtask

   task automatic t_reset_start();
      #0 rst_n = 1'b0;
      #30;
      check("R11 reset gates", src_on, 2'b00);
      check("R11 reset output", {1'b0, clk_out}, 2'b00);
      @(posedge clk_pri);
      #1 rst_n = 1'b1;
      begin
         int base = pri_negs;
         wait_pri(base, 2);
         check("R1 not yet open", src_on, 2'b00);
         wait_pri(base, 3);
         check("R1 open on third edge", src_on, 2'b01);
      end
      mon_en = 1'b1;
      t_follow(1'b0, "R2 primary follow");
   endtask

   task automatic t_to_sec();
      int base;
      int sbase;
      @(negedge clk_pri);
      #1 sel_sec = 1'b1;
      base = pri_negs;
      wait_pri(base, 2);
      check("R3 old still open", src_on, 2'b01);
      wait (pri_negs == base + 3);
      sbase = sec_negs;
      #1;
      check("R3 old closed", src_on, 2'b00);
      check("R3 parked low", {1'b0, clk_out}, 2'b00);
      wait_sec(sbase, 2);
      check("R4 new not yet open", src_on, 2'b00);
      check("R3 still low", {1'b0, clk_out}, 2'b00);
      wait_sec(sbase, 3);
      check("R4 new open third edge", src_on, 2'b10);
      t_follow(1'b1, "R2 secondary follow");
   endtask

   task automatic t_to_pri();
      int base;
      int sbase;
      @(negedge clk_sec);
      #1 sel_sec = 1'b0;
      sbase = sec_negs;
      wait_sec(sbase, 2);
      check("R3 sec still open", src_on, 2'b10);
      wait (sec_negs == sbase + 3);
      base = pri_negs;
      #1;
      check("R3 sec closed", src_on, 2'b00);
      wait_pri(base, 2);
      check("R4 pri not yet open", src_on, 2'b00);
      wait_pri(base, 3);
      check("R4 pri open third edge", src_on, 2'b01);
      t_follow(1'b0, "R2 primary again");
   endtask

   task automatic t_toggle_back();
      int base;
      @(negedge clk_pri);
      #1 sel_sec = 1'b1;
      @(negedge clk_pri);
      #1 sel_sec = 1'b0;
      base = pri_negs;
      for (int k = 1; k <= 8; k++) begin
         wait_pri(base, k);
         if (src_on[1]) check("R9 other never opens", src_on, 2'b01);
      end
      check("R9 original restored", src_on, 2'b01);
      t_follow(1'b0, "R9 follows primary");
   endtask

   task automatic t_force();
      int sbase;
      @(negedge clk_pri);
      #1 pri_run = 1'b0;
      #20;
      check("R7 primary stopped low", {1'b0, clk_pri}, 2'b00);
      check("R7 gate held without clock", src_on, 2'b01);
      force_sw = 1'b1;
      sel_sec  = 1'b1;
      sbase    = sec_negs;
      #1;
      check("R7 old cleared at once", src_on, 2'b00);
      wait_sec(sbase, 2);
      check("R7 new not yet open", src_on, 2'b00);
      wait_sec(sbase, 3);
      check("R7 new open third edge", src_on, 2'b10);
      t_follow(1'b1, "R7 follows secondary");
      force_sw = 1'b0;
      pri_run  = 1'b1;
      #100;
      check("R7 stays on secondary", src_on, 2'b10);
   endtask

   task automatic t_enable();
      mon_en = 1'b0;
      @(negedge clk_sec);
      #1;
      park_lvl = 1'b1;
      out_en   = 1'b0;
      #1 check("R8 parks high", {1'b0, clk_out}, 2'b01);
      @(posedge clk_sec);
      #2 check("R8 high while clock high", {1'b0, clk_out}, 2'b01);
      @(negedge clk_sec);
      #2 check("R8 high while clock low", {1'b0, clk_out}, 2'b01);
      park_lvl = 1'b0;
      #1 check("R8 parks low", {1'b0, clk_out}, 2'b00);
      @(posedge clk_sec);
      #2 check("R8 low while clock high", {1'b0, clk_out}, 2'b00);
      check("R8 gates untouched", src_on, 2'b10);
      @(negedge clk_sec);
      #1 out_en = 1'b1;
      mon_en = 1'b1;
      t_follow(1'b1, "R8 resumes");
   endtask

   task automatic t_reset_mid();
      int sbase;
      mon_en = 1'b0;
      @(posedge clk_sec);
      #2 rst_n = 1'b0;
      #1;
      check("R11 async clear", src_on, 2'b00);
      check("R11 output low", {1'b0, clk_out}, 2'b00);
      @(posedge clk_pri);
      #1 rst_n = 1'b1;
      sbase = sec_negs;
      wait_sec(sbase, 2);
      check("R1 sec not yet open", src_on, 2'b00);
      wait_sec(sbase, 3);
      check("R1 sec open third edge", src_on, 2'b10);
      mon_en = 1'b1;
      t_follow(1'b1, "R2 sec after reset");
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset_start();
      t_to_sec();
      t_to_pri();
      t_toggle_back();
      t_force();
      t_enable();
      t_to_pri();
      t_to_sec();
      t_reset_mid();
      check("R5 gates never both open", {1'b0, overlap_seen != 0}, 2'b00);
      check("R6 no runt pulse", {1'b0, runt_seen != 0}, 2'b00);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule